// File: doc/BRIEF.md
# Extended-Float to Signed Integer Store Converter

This block sits on a store-to-memory path. It takes an 80-bit extended-precision floating-point operand and turns it into a signed byte, word or longword integer. The conversion is started by a one-cycle strobe that also samples the operand and its controls. After a fixed two-cycle latency the block returns a 32-bit result, a one-cycle done pulse and an operand-error flag. In-range values are rounded under one of four rounding modes.

The operand format has a sign bit in bit 79, a 15-bit exponent biased by 16383 in bits 78:64, and a 64-bit significand with an explicit integer bit in bits 63:0. An all-ones exponent with a zero fraction (bits 62:0) is an infinity. An all-ones exponent with any non-zero fraction is a NaN.

There are three ways to get an operand error. The first is a rounded value too large for the chosen size, and the second is an infinity; in both cases the result saturates toward the source sign. The third is a NaN, whose leading significand bits are stored instead. The result is written the same way whether or not the trap is enabled. When the trap is enabled, an exception request also pulses for one cycle.

Top module: `xf_int_store`

## Requirements
- R1: `done` pulses high for exactly one cycle, in the second clock cycle after the cycle in which `start` was sampled high.
- R2: `result`, `op_err` and `exc_req`-free state hold their values from one `done` pulse until the next; input changes without `start` have no effect on them.
- R3: An in-range finite operand is rounded to an integer by `rmode`: 00 nearest with ties to even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity.
- R4: `size` selects the destination: 00 byte, 01 word, 10 or 11 longword. Numeric results are sign-extended from the selected size to 32 bits.
- R5: If the rounded value exceeds the selected size, `op_err` is set. The result is then 2^(n-1)-1 for a positive source or -2^(n-1) for a negative one, where n is 8, 16 or 32. Overflow is judged after rounding.
- R6: An infinite operand sets `op_err` and gives the same saturated value as R5, chosen by its sign.
- R7: A NaN operand sets `op_err`. The result is the top 8, 16 or 32 significand bits (bits 63 downward), zero-extended to 32 bits, and the NaN's sign is ignored.
- R8: Zero and denormal operands that round to zero give a zero result, with `op_err` low.
- R9: `exc_req` pulses together with `done` exactly when `op_err` is set and `trap_en` was high at start. The result is identical with the trap enabled or disabled.
- R10: After reset, `result` is zero and `done`, `op_err` and `exc_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion; samples operand and controls |
| src | input | 80 | Extended-precision operand |
| size | input | 2 | Destination size select |
| rmode | input | 2 | Rounding mode select |
| trap_en | input | 1 | Operand-error trap enable |
| result | output | 32 | Converted integer, held until next conversion |
| done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Operand-error flag, held with result |
| exc_req | output | 1 | One-cycle exception request |

## Verification
The assertions watch the timing and gating on every cycle. They check the two-cycle start-to-done spacing and that outputs stay frozen between done pulses. They check that the exception request appears only with done and a set operand-error flag whenever the trap was enabled. They also check that any clean byte result stays within the sign-extended byte range. The actual converted values only show up in the bench's scenarios: rounding ties in each mode, saturation just past each size limit, infinities of both signs, NaN payload bits at each size, and tiny or zero inputs.

// File: rtl/xf_int_pkg.sv
package xf_int_pkg;

    localparam int unsigned XF_EXP_W = 15;
    localparam int unsigned XF_SIG_W = 64;
    localparam int unsigned XF_OUT_W = 32;
    localparam int unsigned XF_SRC_W = 1 + XF_EXP_W + XF_SIG_W;
    localparam int          XF_BIAS  = (1 << (XF_EXP_W - 1)) - 1;
    localparam int unsigned XF_E_W   = XF_EXP_W + 2;
    localparam int unsigned XF_SH_W  = $clog2(2 * XF_SIG_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LONG_ALT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_ZERO = 2'b01,
        RND_DOWN = 2'b10,
        RND_UP   = 2'b11
    } rnd_e;

    typedef enum logic [1:0] {
        CL_FINITE = 2'b00,
        CL_INF    = 2'b01,
        CL_NAN    = 2'b10
    } cls_e;

    typedef struct packed {
        logic                  sign;
        cls_e                  cls;
        logic                  big;
        logic [XF_OUT_W:0]     mag;
        logic                  guard;
        logic                  sticky;
        logic [XF_OUT_W-1:0]   nan_top;
        size_e                 size;
        rnd_e                  rm;
        logic                  trap;
    } stage_t;

    function automatic int unsigned size_bits(size_e s);
        case (s)
            SZ_BYTE: return 8;
            SZ_WORD: return 16;
            default: return XF_OUT_W;
        endcase
    endfunction

endpackage

// File: rtl/xf_classify.sv
module xf_classify
    import xf_int_pkg::*;
(
    input  logic [XF_SRC_W-1:0]        src,
    output logic                       sign,
    output cls_e                       cls,
    output logic signed [XF_E_W-1:0]   e_unb,
    output logic [XF_SIG_W-1:0]        sig
);
    logic [XF_EXP_W-1:0] exp_f;
    logic [XF_EXP_W-1:0] exp_eff;

    always_comb begin
        sign    = src[XF_SRC_W-1];
        exp_f   = src[XF_SIG_W +: XF_EXP_W];
        sig     = src[XF_SIG_W-1:0];
        exp_eff = (exp_f == '0) ? XF_EXP_W'(1) : exp_f;
        e_unb   = $signed({2'b00, exp_eff}) - $signed(XF_E_W'(XF_BIAS));
        if (exp_f != '1)
            cls = CL_FINITE;
        else if (sig[XF_SIG_W-2:0] == '0)
            cls = CL_INF;
        else
            cls = CL_NAN;
    end
endmodule

// File: rtl/xf_align.sv
module xf_align
    import xf_int_pkg::*;
(
    input  logic [XF_SIG_W-1:0]        sig,
    input  logic signed [XF_E_W-1:0]   e_unb,
    output logic                       big,
    output logic [XF_OUT_W:0]          mag,
    output logic                       guard,
    output logic                       sticky
);
    logic [XF_SH_W-1:0]    sh;
    logic                  far;
    logic [2*XF_SIG_W-1:0] wide;
    int                    ei;

    always_comb begin
        ei  = int'(e_unb);
        big = (ei >= int'(XF_OUT_W));
        far = 1'b0;
        if (big)
            sh = '0;
        else if (ei < -int'(XF_SIG_W)) begin
            sh  = '1;
            far = 1'b1;
        end else
            sh = XF_SH_W'(int'(XF_SIG_W) - 1 - ei);
        wide   = {sig, {XF_SIG_W{1'b0}}} >> sh;
        mag    = wide[XF_SIG_W +: XF_OUT_W+1];
        guard  = wide[XF_SIG_W-1];
        sticky = (|wide[XF_SIG_W-2:0]) | (far & (|sig));
    end
endmodule

// File: rtl/xf_round_sat.sv
module xf_round_sat
    import xf_int_pkg::*;
(
    input  stage_t              st,
    output logic [XF_OUT_W-1:0] res,
    output logic                err
);
    logic              inc;
    logic [XF_OUT_W:0] mag_r;
    logic [XF_OUT_W:0] lim_pos;
    logic [XF_OUT_W:0] lim_neg;
    logic [XF_OUT_W:0] neg_v;
    logic [XF_OUT_W:0] sat_v;
    logic              ovf;
    int unsigned       n;

    always_comb begin
        case (st.rm)
            RND_NEAR: inc = st.guard & (st.sticky | st.mag[0]);
            RND_ZERO: inc = 1'b0;
            RND_DOWN: inc = st.sign & (st.guard | st.sticky);
            default:  inc = ~st.sign & (st.guard | st.sticky);
        endcase
        mag_r   = st.mag + {{XF_OUT_W{1'b0}}, inc};
        n       = size_bits(st.size);
        lim_neg = (XF_OUT_W+1)'(1) << (n - 1);
        lim_pos = lim_neg - (XF_OUT_W+1)'(1);
        ovf     = st.big | (st.sign ? (mag_r > lim_neg) : (mag_r > lim_pos));
        neg_v   = ~mag_r + (XF_OUT_W+1)'(1);
        sat_v   = st.sign ? (~lim_neg + (XF_OUT_W+1)'(1)) : lim_pos;

        if (st.cls == CL_NAN) begin
            err = 1'b1;
            case (st.size)
                SZ_BYTE: res = {{(XF_OUT_W-8){1'b0}},  st.nan_top[XF_OUT_W-1 -: 8]};
                SZ_WORD: res = {{(XF_OUT_W-16){1'b0}}, st.nan_top[XF_OUT_W-1 -: 16]};
                default: res = st.nan_top;
            endcase
        end else if (st.cls == CL_INF || ovf) begin
            err = 1'b1;
            res = sat_v[XF_OUT_W-1:0];
        end else begin
            err = 1'b0;
            res = st.sign ? neg_v[XF_OUT_W-1:0] : mag_r[XF_OUT_W-1:0];
        end
    end
endmodule

// File: rtl/xf_int_store.sv
module xf_int_store
    import xf_int_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [XF_SRC_W-1:0] src,
    input  logic [1:0]          size,
    input  logic [1:0]          rmode,
    input  logic                trap_en,
    output logic [XF_OUT_W-1:0] result,
    output logic                done,
    output logic                op_err,
    output logic                exc_req
);
    logic                     c_sign;
    cls_e                     c_cls;
    logic signed [XF_E_W-1:0] c_e;
    logic [XF_SIG_W-1:0]      c_sig;
    logic                     a_big;
    logic [XF_OUT_W:0]        a_mag;
    logic                     a_guard;
    logic                     a_sticky;
    stage_t                   s1_d;
    stage_t                   s1_q;
    logic                     s1_vld;
    logic [XF_OUT_W-1:0]      r_res;
    logic                     r_err;

    xf_classify u_cls (
        .src   (src),
        .sign  (c_sign),
        .cls   (c_cls),
        .e_unb (c_e),
        .sig   (c_sig)
    );

    xf_align u_aln (
        .sig    (c_sig),
        .e_unb  (c_e),
        .big    (a_big),
        .mag    (a_mag),
        .guard  (a_guard),
        .sticky (a_sticky)
    );

    always_comb begin
        s1_d.sign    = c_sign;
        s1_d.cls     = c_cls;
        s1_d.big     = a_big;
        s1_d.mag     = a_mag;
        s1_d.guard   = a_guard;
        s1_d.sticky  = a_sticky;
        s1_d.nan_top = c_sig[XF_SIG_W-1 -: XF_OUT_W];
        s1_d.size    = size_e'(size);
        s1_d.rm      = rnd_e'(rmode);
        s1_d.trap    = trap_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= start;
            if (start)
                s1_q <= s1_d;
        end
    end

    xf_round_sat u_rnd (
        .st  (s1_q),
        .res (r_res),
        .err (r_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            op_err  <= 1'b0;
            done    <= 1'b0;
            exc_req <= 1'b0;
        end else begin
            done    <= s1_vld;
            exc_req <= s1_vld & r_err & s1_q.trap;
            if (s1_vld) begin
                result <= r_res;
                op_err <= r_err;
            end
        end
    end
endmodule

// File: rtl/xf_int_store_chk.sv
module xf_int_store_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  size,
    input logic        trap_en,
    input logic [31:0] result,
    input logic        done,
    input logic        op_err,
    input logic        exc_req
);
    p_done_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start |-> ##2 done);

    p_done_has_start_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 2));

    p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(op_err)));

    p_byte_range_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !op_err && $past(size, 2) == 2'b00)
            |-> (result[31:7] == '0 || result[31:7] == '1));

    p_exc_gated_r9: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (done && op_err));

    p_exc_raised_r9: assert property (@(posedge clk) disable iff (rst)
        (done && op_err && $past(trap_en, 2)) |-> exc_req);
endmodule

bind xf_int_store xf_int_store_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .size    (size),
    .trap_en (trap_en),
    .result  (result),
    .done    (done),
    .op_err  (op_err),
    .exc_req (exc_req)
);

// File: tb/xf_int_store_tb.sv
`timescale 1ns/1ps
module xf_int_store_tb;

    typedef struct packed {
        logic [79:0] src;
        logic [1:0]  sz;
        logic [1:0]  rm;
        logic [31:0] exp_res;
        logic        exp_err;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{80'h3FFF_8000000000000000, 2'd2, 2'd0, 32'h00000001, 1'b0}, // R3 1.0
        '{80'h4000_A000000000000000, 2'd2, 2'd0, 32'h00000002, 1'b0}, // R3 2.5 tie even
        '{80'h4000_A000000000000000, 2'd2, 2'd3, 32'h00000003, 1'b0}, // R3 up
        '{80'h4000_A000000000000000, 2'd2, 2'd1, 32'h00000002, 1'b0}, // R3 zero
        '{80'hC000_A000000000000000, 2'd2, 2'd2, 32'hFFFFFFFD, 1'b0}, // R3 down -2.5
        '{80'hC000_A000000000000000, 2'd2, 2'd1, 32'hFFFFFFFE, 1'b0}, // R3 zero -2.5
        '{80'h4000_E000000000000000, 2'd2, 2'd0, 32'h00000004, 1'b0}, // R3 3.5 tie
        '{80'h4005_FF00000000000000, 2'd0, 2'd0, 32'h0000007F, 1'b1}, // R5 127.5 rounds over
        '{80'h4005_FF00000000000000, 2'd0, 2'd1, 32'h0000007F, 1'b0}, // R5 127.5 truncates in
        '{80'hC006_8000000000000000, 2'd0, 2'd0, 32'hFFFFFF80, 1'b0}, // R4 -128 byte
        '{80'hC006_8100000000000000, 2'd0, 2'd0, 32'hFFFFFF80, 1'b1}, // R5 -129 byte
        '{80'h400E_9C40000000000000, 2'd1, 2'd0, 32'h00007FFF, 1'b1}, // R5 40000 word
        '{80'h400E_9C40000000000000, 2'd2, 2'd0, 32'h00009C40, 1'b0}, // R4 40000 long
        '{80'hC00E_9C40000000000000, 2'd1, 2'd0, 32'hFFFF8000, 1'b1}, // R5 -40000 word
        '{80'h401E_8000000000000000, 2'd2, 2'd0, 32'h7FFFFFFF, 1'b1}, // R5 2^31
        '{80'hC01E_8000000000000000, 2'd3, 2'd0, 32'h80000000, 1'b0}, // R4 -2^31 size 11
        '{80'h7FFF_8000000000000000, 2'd1, 2'd0, 32'h00007FFF, 1'b1}, // R6 +inf word
        '{80'hFFFF_8000000000000000, 2'd2, 2'd1, 32'h80000000, 1'b1}, // R6 -inf long
        '{80'h7FFF_C123456789ABCDEF, 2'd0, 2'd0, 32'h000000C1, 1'b1}, // R7 NaN byte
        '{80'h7FFF_C123456789ABCDEF, 2'd1, 2'd1, 32'h0000C123, 1'b1}, // R7 NaN word
        '{80'hFFFF_C123456789ABCDEF, 2'd2, 2'd0, 32'hC1234567, 1'b1}, // R7 NaN long neg
        '{80'h0000_0000000000000000, 2'd2, 2'd0, 32'h00000000, 1'b0}, // R8 +0
        '{80'h8000_0000000000000000, 2'd1, 2'd2, 32'h00000000, 1'b0}, // R8 -0 down
        '{80'h0000_0000000000000001, 2'd2, 2'd1, 32'h00000000, 1'b0}, // R8 denormal
        '{80'h0000_0000000000000001, 2'd2, 2'd3, 32'h00000001, 1'b0}, // R3 denormal up
        '{80'h8000_0000000000000001, 2'd0, 2'd2, 32'hFFFFFFFF, 1'b0}, // R3 -denormal down
        '{80'h3FFE_8000000000000000, 2'd2, 2'd0, 32'h00000000, 1'b0}, // R8 0.5 tie to 0
        '{80'h3FFE_C000000000000000, 2'd2, 2'd0, 32'h00000001, 1'b0}, // R3 0.75
        '{80'h4040_8000000000000000, 2'd2, 2'd0, 32'h7FFFFFFF, 1'b1}, // R5 2^65
        '{80'hBFFD_8000000000000000, 2'd2, 2'd3, 32'h00000000, 1'b0}, // R8 -0.25 up
        '{80'hBFFD_8000000000000000, 2'd0, 2'd2, 32'hFFFFFFFF, 1'b0}, // R3 -0.25 down
        '{80'h3FFF_C000000000000000, 2'd1, 2'd0, 32'h00000002, 1'b0}  // R3 1.5
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [79:0] src;
    logic [1:0]  size;
    logic [1:0]  rmode;
    logic        trap_en;
    logic [31:0] result;
    logic        done;
    logic        op_err;
    logic        exc_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xf_int_store u_dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .src     (src),
        .size    (size),
        .rmode   (rmode),
        .trap_en (trap_en),
        .result  (result),
        .done    (done),
        .op_err  (op_err),
        .exc_req (exc_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one conversion; checks done timing and returns the outputs seen with done.
    task automatic run(input logic [79:0] s, input logic [1:0] sz, input logic [1:0] rm,
                       input logic tr, output logic [31:0] r, output logic e, output logic x);
        @(negedge clk);
        src = s; size = sz; rmode = rm; trap_en = tr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 done early", {31'b0, done}, 32'd0);
        @(negedge clk);
        chk("R1 done on time", {31'b0, done}, 32'd1);
        r = result; e = op_err; x = exc_req;
        @(negedge clk);
        chk("R1 done one cycle", {31'b0, done}, 32'd0);
        chk("R9 exc_req one cycle", {31'b0, exc_req}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        logic        e, e2, x, x2;
        rst = 1'b1; start = 1'b0; src = '0; size = '0; rmode = '0; trap_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 result", result, 32'd0);
        chk("R10 done", {31'b0, done}, 32'd0);
        chk("R10 op_err", {31'b0, op_err}, 32'd0);
        chk("R10 exc_req", {31'b0, exc_req}, 32'd0);

        // Table walk; trap toggles so R9 gating is seen on both settings
        for (int i = 0; i < NV; i++) begin
            logic tr;
            tr = i[0];
            run(VECS[i].src, VECS[i].sz, VECS[i].rm, tr, r, e, x);
            chk($sformatf("R3-set vector %0d result", i), r, VECS[i].exp_res);
            chk($sformatf("R5 vector %0d op_err", i), {31'b0, e}, {31'b0, VECS[i].exp_err});
            chk($sformatf("R9 vector %0d exc_req", i), {31'b0, x}, {31'b0, VECS[i].exp_err & tr});
        end

        // R2: outputs held while inputs move without start
        run(80'h4000_A000000000000000, 2'd2, 2'd3, 1'b0, r, e, x);
        src = 80'h7FFF_C123456789ABCDEF; size = 2'd0; rmode = 2'd1; trap_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 result held", result, 32'h00000003);
        chk("R2 op_err held", {31'b0, op_err}, 32'd0);
        chk("R2 no done", {31'b0, done}, 32'd0);

        // R9: trap on/off gives same destination for a NaN
        run(80'h7FFF_C123456789ABCDEF, 2'd1, 2'd0, 1'b0, r, e, x);
        run(80'h7FFF_C123456789ABCDEF, 2'd1, 2'd0, 1'b1, r2, e2, x2);
        chk("R9 same result with trap", r2, r);
        chk("R9 exc_req off", {31'b0, x}, 32'd0);
        chk("R9 exc_req on", {31'b0, x2}, 32'd1);
        chk("R7 NaN flag", {31'b0, e2}, 32'd1);

        // R9: trap enabled with no error gives no request
        run(80'h3FFF_8000000000000000, 2'd0, 2'd0, 1'b1, r, e, x);
        chk("R9 no request clean", {31'b0, x}, 32'd0);
        chk("R4 byte one", r, 32'h00000001);

        // R6 -inf byte saturation with trap
        run(80'hFFFF_8000000000000000, 2'd0, 2'd0, 1'b1, r, e, x);
        chk("R6 -inf byte", r, 32'hFFFFFF80);
        chk("R6 -inf exc", {31'b0, x}, 32'd1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule